// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block gives a host a small register window through which it can send one command at a time to a serial NOR flash over a single-bit SPI link. The host sets a mode word, loads a 24-bit flash address, fills a 256-byte payload window if the command carries data, and then writes a command word. That write starts one transaction. The engine emits the opcode. It adds three address bytes when the opcode needs them. It then clocks the requested number of payload bytes, either out of the window or back into it.

The opcode determines the framing. Page program (0x02), sector erase (0x20) and normal read (0x03) carry an address. Read ID (0x9F), status read (0x05), write enable (0x06), chip erase (0x60) and every other opcode do not. Opcodes 0x03, 0x05 and 0x9F bring data in. Every other opcode with a nonzero count sends window bytes out. The host polls the status word until the busy flag drops and then reads any received bytes from the window.

The host port takes one request in every cycle in which `bus_valid` is high. There is no back-pressure. A read returns its data one cycle later, with `bus_rvalid` high for that cycle.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset the status word reads 0, the mode word and the address word read 0, `spi_cs_n` is 1 and `spi_sck` is 0.
- R2: The mode word at offset 0x000 reads back any 32-bit value written to it. The address word at 0x008 keeps bits [23:0] of the value written and reads back with bits [31:24] as 0.
- R3: A write to offset 0x00C starts a transaction only when the mode word equals 0x371. On the next cycle, bit 0 of the status word at 0x004 reads 1. The command word carries the opcode in bits [7:0] and the byte count in bits [31:16]. When the mode word holds any other value, such a write has no effect.
- R4: `spi_cs_n` stays low for the whole transaction. SCK idles low and MOSI is stable at each rising edge (mode 0). Bytes go out MSB first. Each SCK half-period lasts HALF_DIV clocks. Only opcodes 0x02, 0x20 and 0x03 are followed by the 24-bit address, sent most significant byte first.
- R5: Opcodes other than 0x03, 0x05 and 0x9F send window bytes 0 to count-1 after the header. Window byte n is bits [8*(n%4)+7 : 8*(n%4)] of the word at offset 0x100 + 4*(n/4). A count above 256 is treated as 256.
- R6: For opcodes 0x03, 0x05 and 0x9F, the k-th received data byte is stored in window byte k. MOSI is 0 during those data bytes, and the window bytes beyond the count keep their values.
- R7: With a count of 0 only the header is sent: 8 SCK pulses for opcodes without an address and 32 pulses for 0x20.
- R8: The busy flag clears one cycle after `spi_cs_n` rises. `spi_cs_n` stays high for at least one clock between two transactions.
- R9: While busy is set, writes to the command word, the address word and the data window are ignored.
- R10: Read data appears on `bus_rvalid`/`bus_rdata` one cycle after the request. Reads of the command word and of unmapped register offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Host request present this cycle (always accepted) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset; bit 8 selects the data window |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A corrupted phase or byte index shows up on the SPI pins within one byte time: a missing or extra address byte, a wrong SCK pulse count per frame, or a data byte taken from the wrong window position. A bench-side flash model catches each of these by comparing the captured MOSI bytes and the pulse count against the expected frame. A stuck or misordered busy flag shows up on the status word and on the chip-select gap within a cycle or two of the frame ending. A receive path that stores bytes in the wrong place shows up on the first window read-back after an identification read.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_SECT   = 8'h20;
  localparam logic [7:0] OP_RDID   = 8'h9F;

  typedef enum logic [1:0] {PH_OPC, PH_ADR, PH_DAT} phase_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_WAIT, SQ_GAP} seq_st_t;

  function automatic logic op_has_addr(input logic [7:0] op);
    return (op == OP_PROG) || (op == OP_SECT) || (op == OP_READ);
  endfunction

  function automatic logic op_is_read(input logic [7:0] op);
    return (op == OP_READ) || (op == OP_RDSR) || (op == OP_RDID);
  endfunction
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int CNT_W = $clog2(HALF_DIV) + 1;

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bits;
  logic [7:0]       sh;

  assign mosi = sh[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      sck     <= 1'b0;
      cnt     <= '0;
      bits    <= '0;
      sh      <= '0;
      rx_byte <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        sh     <= tx_byte;
        sck    <= 1'b0;
        cnt    <= '0;
        bits   <= '0;
      end else if (active) begin
        if (cnt == CNT_W'(HALF_DIV - 1)) begin
          cnt <= '0;
          if (!sck) begin
            sck     <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bits == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bits <= bits + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assert_mosi_stable_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> $stable(mosi));
  assert_sck_idle_low_R4: assert property (@(posedge clk) disable iff (rst)
    !active |-> !sck);
endmodule

// File: rtl/spi_window.sv
module spi_window #(
  parameter int WIN_BYTES = 256
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         h_we,
  input  logic [$clog2(WIN_BYTES)-3:0] h_widx,
  input  logic [31:0]                  h_wdata,
  output logic [31:0]                  h_rdata,
  input  logic                         e_we,
  input  logic [$clog2(WIN_BYTES)-1:0] e_bidx,
  input  logic [7:0]                   e_wbyte,
  output logic [7:0]                   e_rbyte
);
  localparam int WORDS = WIN_BYTES / 4;
  localparam int BW    = $clog2(WIN_BYTES);

  logic [31:0] mem [WORDS];
  logic [BW-3:0] e_word;
  logic [1:0]    e_lane;

  assign e_word  = e_bidx[BW-1:2];
  assign e_lane  = e_bidx[1:0];
  assign h_rdata = mem[h_widx];
  assign e_rbyte = mem[e_word][{e_lane, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else if (e_we) begin
      mem[e_word][{e_lane, 3'b000} +: 8] <= e_wbyte;
    end else if (h_we) begin
      mem[h_widx] <= h_wdata;
    end
  end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_eng_pkg::*;
#(
  parameter int WIN_BYTES = 256
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         go,
  input  logic [7:0]                   go_op,
  input  logic [$clog2(WIN_BYTES):0]   go_cnt,
  input  logic [23:0]                  go_addr,
  output logic                         busy,
  output logic                         cs_n,
  output logic                         sh_start,
  output logic [7:0]                   sh_tx,
  input  logic                         sh_done,
  input  logic [7:0]                   sh_rx,
  output logic                         win_we,
  output logic [$clog2(WIN_BYTES)-1:0] win_bidx,
  output logic [7:0]                   win_wbyte,
  input  logic [7:0]                   win_rbyte
);
  localparam int CNT_W = $clog2(WIN_BYTES) + 1;
  localparam int BW    = $clog2(WIN_BYTES);

  seq_st_t          st;
  phase_t           ph;
  logic [7:0]       op_q;
  logic [23:0]      addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx;
  logic             rd_q;

  logic   last_byte;
  phase_t nxt_ph;

  always_comb begin
    last_byte = 1'b0;
    nxt_ph    = ph;
    unique case (ph)
      PH_OPC: begin
        if (op_has_addr(op_q)) nxt_ph = PH_ADR;
        else if (cnt_q != '0) nxt_ph = PH_DAT;
        else last_byte = 1'b1;
      end
      PH_ADR: begin
        if (idx == CNT_W'(2)) begin
          if (cnt_q != '0) nxt_ph = PH_DAT;
          else last_byte = 1'b1;
        end
      end
      default: last_byte = (idx == cnt_q - CNT_W'(1));
    endcase
  end

  always_comb begin
    sh_start  = (st == SQ_LOAD);
    win_bidx  = idx[BW-1:0];
    win_wbyte = sh_rx;
    win_we    = (st == SQ_WAIT) && sh_done && (ph == PH_DAT) && rd_q;
    unique case (ph)
      PH_OPC:  sh_tx = op_q;
      PH_ADR:  sh_tx = (idx == '0) ? addr_q[23:16] :
                       (idx == CNT_W'(1)) ? addr_q[15:8] : addr_q[7:0];
      default: sh_tx = rd_q ? 8'h00 : win_rbyte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SQ_IDLE;
      ph     <= PH_OPC;
      op_q   <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      idx    <= '0;
      rd_q   <= 1'b0;
      busy   <= 1'b0;
      cs_n   <= 1'b1;
    end else begin
      unique case (st)
        SQ_IDLE: if (go) begin
          op_q   <= go_op;
          addr_q <= go_addr;
          cnt_q  <= go_cnt;
          rd_q   <= op_is_read(go_op);
          ph     <= PH_OPC;
          idx    <= '0;
          busy   <= 1'b1;
          cs_n   <= 1'b0;
          st     <= SQ_LOAD;
        end
        SQ_LOAD: st <= SQ_WAIT;
        SQ_WAIT: if (sh_done) begin
          if (last_byte) begin
            cs_n <= 1'b1;
            st   <= SQ_GAP;
          end else begin
            idx <= (nxt_ph != ph) ? '0 : idx + CNT_W'(1);
            ph  <= nxt_ph;
            st  <= SQ_LOAD;
          end
        end
        default: begin
          busy <= 1'b0;
          st   <= SQ_IDLE;
        end
      endcase
    end
  end

  assert_cs_within_busy_R4: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);
  assert_busy_after_cs_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (cs_n && $past(cs_n)));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int          WIN_BYTES     = 256,
  parameter int          HALF_DIV      = 2,
  parameter logic [31:0] CMD_MODE_WORD = 32'h0000_0371
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [8:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic        bus_rvalid,
  output logic [31:0] bus_rdata,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int BW    = $clog2(WIN_BYTES);
  localparam int CNT_W = BW + 1;
  localparam int AW    = BW + 1;

  logic [31:0] mode_q;
  logic [23:0] addr_q;
  logic        busy;

  logic        in_win;
  logic [7:0]  reg_off;
  logic        wr_mode, wr_addr, wr_cmd, wr_win, go;
  logic [15:0] raw_cnt;
  logic [CNT_W-1:0] eff_cnt;

  logic        sh_start, sh_done;
  logic [7:0]  sh_tx, sh_rx;
  logic        e_we;
  logic [BW-1:0] e_bidx;
  logic [7:0]  e_wbyte, e_rbyte;
  logic [31:0] win_rdata;

  assign in_win  = bus_addr[AW-1];
  assign reg_off = bus_addr[7:0];
  assign wr_mode = bus_valid && bus_write && !in_win && (reg_off == 8'h00);
  assign wr_addr = bus_valid && bus_write && !in_win && (reg_off == 8'h08) && !busy;
  assign wr_cmd  = bus_valid && bus_write && !in_win && (reg_off == 8'h0C);
  assign wr_win  = bus_valid && bus_write && in_win && !busy;
  assign go      = wr_cmd && !busy && (mode_q == CMD_MODE_WORD);
  assign raw_cnt = bus_wdata[31:16];
  assign eff_cnt = (raw_cnt > 16'(WIN_BYTES)) ? CNT_W'(WIN_BYTES) : CNT_W'(raw_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      addr_q     <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata;
      if (wr_addr) addr_q <= bus_wdata[23:0];
      bus_rvalid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) begin
        if (in_win) bus_rdata <= win_rdata;
        else begin
          unique case (reg_off)
            8'h00:   bus_rdata <= mode_q;
            8'h04:   bus_rdata <= {31'b0, busy};
            8'h08:   bus_rdata <= {8'b0, addr_q};
            default: bus_rdata <= '0;
          endcase
        end
      end
    end
  end

  spi_window #(.WIN_BYTES(WIN_BYTES)) u_win (
    .clk(clk), .rst(rst),
    .h_we(wr_win), .h_widx(bus_addr[BW-1:2]), .h_wdata(bus_wdata), .h_rdata(win_rdata),
    .e_we(e_we), .e_bidx(e_bidx), .e_wbyte(e_wbyte), .e_rbyte(e_rbyte)
  );

  spi_cmd_seq #(.WIN_BYTES(WIN_BYTES)) u_seq (
    .clk(clk), .rst(rst),
    .go(go), .go_op(bus_wdata[7:0]), .go_cnt(eff_cnt), .go_addr(addr_q),
    .busy(busy), .cs_n(spi_cs_n),
    .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx),
    .win_we(e_we), .win_bidx(e_bidx), .win_wbyte(e_wbyte), .win_rbyte(e_rbyte)
  );

  spi_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst(rst),
    .start(sh_start), .tx_byte(sh_tx), .done(sh_done), .rx_byte(sh_rx),
    .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
  );

  assert_sck_only_selected_R4: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);
  assert_cmd_ignored_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !spi_cs_n && wr_cmd) |=> !spi_cs_n);
endmodule

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
  localparam int HALF = 2;

  logic clk = 0, rst = 1;
  logic bus_valid = 0, bus_write = 0;
  logic [8:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic bus_rvalid;
  logic [31:0] bus_rdata;
  logic cs_n, sck, mosi, miso;

  int checks = 0, fails = 0;
  int bitcnt = 0, frames = 0;
  logic [7:0] cap [300];
  logic [7:0] resp [300];
  logic [7:0] shreg = 0;
  int cyc = 0, last_rise = 0, sck_per = 0, hi_run = 0, last_gap = 0;

  always #5 clk = ~clk;

  spi_cmd_engine dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso)
  );

  assign miso = (bitcnt < 2400) ? resp[bitcnt / 8][7 - (bitcnt % 8)] : 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cs_n) hi_run++;
    else begin
      if (hi_run != 0) last_gap = hi_run;
      hi_run = 0;
    end
  end

  always @(negedge cs_n or posedge sck) begin
    if (sck) begin
      shreg = {shreg[6:0], mosi};
      if (bitcnt % 8 == 7 && bitcnt < 2400) cap[bitcnt / 8] = shreg;
      bitcnt++;
      sck_per = cyc - last_rise;
      last_rise = cyc;
    end else begin
      bitcnt = 0;
      frames++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
    if (!bus_rvalid) chk("R10 rvalid", 0, 1);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(9'h004, s);
      if (s[0] == 1'b0) return;
    end
    chk("R8 busy stuck", 1, 0);
  endtask

  function automatic logic [7:0] pat(input int n);
    return 8'((n * 7 + 3) ^ 8'h5A);
  endfunction

  task automatic fill_window();
    for (int w = 0; w < 64; w++)
      wr(9'h100 + 9'(w * 4), {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 cs_n", 32'(cs_n), 1);
    chk("R1 sck", 32'(sck), 0);
    rd(9'h004, d); chk("R1 status", d, 0);
    rd(9'h000, d); chk("R1 mode", d, 0);
    rd(9'h008, d); chk("R1 addr", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(9'h000, 32'h0000_0372); rd(9'h000, d); chk("R2 mode 372", d, 32'h372);
    wr(9'h000, 32'hDEAD_BEEF); rd(9'h000, d); chk("R2 mode any", d, 32'hDEADBEEF);
    wr(9'h008, 32'hABCD_EF12); rd(9'h008, d); chk("R2 addr 24b", d, 32'h00CDEF12);
    rd(9'h00C, d); chk("R10 cmd reads 0", d, 0);
    rd(9'h010, d); chk("R10 unmapped 0", d, 0);
  endtask

  task automatic t_mode_gate();
    logic [31:0] d;
    int f0;
    wr(9'h000, 32'h372);
    f0 = frames;
    wr(9'h00C, 32'h06);
    rd(9'h004, d); chk("R3 gated status", d, 0);
    repeat (50) @(negedge clk);
    chk("R3 gated no frame", 32'(frames - f0), 0);
    wr(9'h000, 32'h371);
  endtask

  task automatic t_wren();
    logic [31:0] d;
    wr(9'h00C, 32'h06);
    rd(9'h004, d); chk("R3 busy set", d, 1);
    wait_idle();
    chk("R7 wren pulses", 32'(bitcnt), 8);
    chk("R4 wren opcode", 32'(cap[0]), 32'h06);
    chk("R4 sck period", 32'(sck_per), 2 * HALF);
    wr(9'h00C, 32'h06);
    wait_idle();
    chk("R8 cs gap >=1", 32'(last_gap >= 1), 1);
  endtask

  task automatic t_erase();
    wr(9'h008, 32'h0001_2345);
    wr(9'h00C, 32'h20);
    wait_idle();
    chk("R7 erase pulses", 32'(bitcnt), 32);
    chk("R4 erase hdr", {cap[0], cap[1], cap[2], cap[3]}, 32'h20012345);
    wr(9'h00C, 32'h60);
    wait_idle();
    chk("R7 chip erase pulses", 32'(bitcnt), 8);
    chk("R7 chip erase op", 32'(cap[0]), 32'h60);
  endtask

  task automatic t_prog();
    int bad;
    fill_window();
    wr(9'h008, 32'h0000_0100);
    wr(9'h00C, 32'h0005_0002);
    wait_idle();
    chk("R5 pp pulses", 32'(bitcnt), 72);
    chk("R5 pp hdr", {cap[0], cap[1], cap[2], cap[3]}, 32'h02000100);
    bad = 0;
    for (int n = 0; n < 5; n++) if (cap[4+n] !== pat(n)) bad++;
    chk("R5 pp data", 32'(bad), 0);
    wr(9'h00C, 32'h012C_0002);
    wait_idle();
    chk("R5 clip 256", 32'(bitcnt), (4 + 256) * 8);
    bad = 0;
    for (int n = 0; n < 256; n++) if (cap[4+n] !== pat(n)) bad++;
    chk("R5 full page data", 32'(bad), 0);
  endtask

  task automatic t_rdid();
    logic [31:0] d;
    resp[1] = 8'hEF; resp[2] = 8'h40; resp[3] = 8'h13;
    wr(9'h100, 32'hA5A5_A5A5);
    wr(9'h00C, 32'h0003_009F);
    wait_idle();
    chk("R6 rdid pulses", 32'(bitcnt), 32);
    chk("R6 mosi zero", {8'h0, cap[1], cap[2], cap[3]}, 0);
    rd(9'h100, d); chk("R6 id stored", d, 32'hA51340EF);
    resp[4] = 8'h3C; resp[5] = 8'hC3;
    wr(9'h008, 32'h0000_0040);
    wr(9'h00C, 32'h0002_0003);
    wait_idle();
    chk("R4 read has addr", {cap[0], cap[1], cap[2], cap[3]}, 32'h03000040);
    rd(9'h100, d); chk("R6 read stored", d, 32'hA513C33C);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    int f0;
    wr(9'h100, 32'h1122_3344);
    wr(9'h008, 32'h0000_0200);
    f0 = frames;
    wr(9'h00C, 32'h0004_0002);
    wr(9'h008, 32'h0077_7777);
    wr(9'h100, 32'hFFFF_FFFF);
    wr(9'h00C, 32'h60);
    wait_idle();
    repeat (40) @(negedge clk);
    chk("R9 one frame", 32'(frames - f0), 1);
    chk("R9 frame length", 32'(bitcnt), 64);
    rd(9'h008, d); chk("R9 addr kept", d, 32'h200);
    rd(9'h100, d); chk("R9 window kept", d, 32'h11223344);
  endtask

  initial begin
    for (int i = 0; i < 300; i++) resp[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_mode_gate();
    t_wren();
    t_erase();
    t_prog();
    t_rdid();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule